// File: doc/BRIEF.md
# Ping-Pong Piecewise-Linear Curve Table

This block applies a per-channel transfer curve (degamma or regamma) to a pixel stream. The curve is held as a table of points, where each point has a base value and a slope delta for red, green and blue. Two copies of the table exist. One copy is live and serves pixel lookups. Software refills the other copy through a single auto-incrementing data port, then asks for a switch. The switch is taken at the next frame boundary, so no frame is ever processed with two different curves.

Each incoming pixel component is split into two parts. The upper bits select a point and the lower bits are a fraction. The output is the point's base plus the delta scaled by that fraction. In bypass the component passes through unchanged, zero-extended to the output width.

Top module: `pwl_pingpong_lut`

## Requirements
- R1: After reset, `status_o` is 0, `pix_vld_o` is 0, all three outputs are 0, the lookup mode is bypass and the write position is point 0, word 0.
- R2: Accepted data words fill a point in this fixed order: word 0 is red base, word 1 green base, word 2 blue base, word 3 red delta, word 4 green delta, word 5 blue delta. After word 5 the point index increases by one and the word count returns to 0.
- R3: Bit 0 of `wr_mask_i` enables red, bit 1 enables green and bit 2 enables blue. When a word's channel bit is 0, that word is not stored, but it still advances the word count. The value 7 stores all channels.
- R4: When `wr_sel_i` is 0, words go to table A. When it is 1, words go to table B. Writing one table never changes lookups served from the other table.
- R5: A pulse on `idx_clr_i` returns the write position to point 0, word 0. A data word presented in the same cycle as the pulse is dropped.
- R6: Once point NPTS-1 (63 by default) has received its sixth word, further data words are ignored until `idx_clr_i` is pulsed.
- R7: A write on `mode_wr_i` stages a lookup mode: code 0 is bypass, code 3 is table A and code 4 is table B. Any other code leaves the staged mode unchanged. The staged mode becomes active on the first `frame_start_i` after the cycle of the write. A write in the same cycle as `frame_start_i` therefore waits for the following frame start.
- R8: `status_o` reads 9 while table A is active, 10 while table B is active, and 0 in bypass.
- R9: In a table mode, a component `p` (PIX_W = IDX_W+FW bits) selects point `p[PIX_W-1:FW]` with fraction `f = p[FW-1:0]`. The output is `(base + ((delta*f) >> FW)) mod 2^DW`. `pix_vld_o` and the data appear two cycles after `pix_vld_i`.
- R10: In bypass, each output equals its input component zero-extended to DW bits, with the same two-cycle latency.
- R11: The table a pixel reads is fixed by the mode active in the cycle the pixel enters. A table read and a write to the same entry in the same cycle return the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_sel_i | input | 1 | Target table for data words (0 = A, 1 = B) |
| wr_mask_i | input | 3 | Channel write enables (bit 0 = R, bit 1 = G, bit 2 = B) |
| idx_clr_i | input | 1 | Returns the write position to point 0, word 0 |
| data_vld_i | input | 1 | Data word strobe |
| data_i | input | DW | Data word |
| mode_wr_i | input | 1 | Stages `mode_i` as the next lookup mode |
| mode_i | input | 3 | Mode code: 0 bypass, 3 table A, 4 table B |
| frame_start_i | input | 1 | Frame boundary; the staged mode becomes active |
| status_o | output | 4 | Active table: 0 bypass, 9 table A, 10 table B |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_r_i | input | PIX_W | Red component: point index and fraction |
| pix_g_i | input | PIX_W | Green component: point index and fraction |
| pix_b_i | input | PIX_W | Blue component: point index and fraction |
| pix_vld_o | output | 1 | Output pixel valid |
| out_r_o | output | DW | Red result |
| out_g_o | output | DW | Green result |
| out_b_o | output | DW | Blue result |

## Verification
Random pixel components are sent through bypass, table A and table B. Bypass output must echo the input. Table output must match a base-plus-scaled-delta computation, which tells a correct table lookup from a bypass leak or from reading the wrong table.

Directed components at fraction 0, at full fraction and at the last point separate off-by-one errors in the index split and errors in the scaling shift.

Tables are reloaded while the other table is live, with masks and interrupted sequences. This shows whether the word-order decode, the channel gating, the write-position restart and the overflow guard touch only the idle table, and only the intended entries. Mode writes are placed both before a frame start and in the same cycle as one, which shows whether a switch lands at the correct boundary.

// File: rtl/pwl_lut_pkg.sv
package pwl_lut_pkg;
  typedef enum logic [2:0] {
    MODE_BYP   = 3'd0,
    MODE_RAM_A = 3'd3,
    MODE_RAM_B = 3'd4
  } lut_mode_e;

  localparam logic [3:0] STAT_BYP = 4'd0;
  localparam logic [3:0] STAT_A   = 4'd9;
  localparam logic [3:0] STAT_B   = 4'd10;

  localparam int CH_N       = 3;
  localparam int WORDS_PT   = 6;
  localparam int BANK_N     = 2;

  function automatic logic mode_code_ok(input logic [2:0] code);
    return (code == 3'd0) || (code == 3'd3) || (code == 3'd4);
  endfunction
endpackage

// File: rtl/pwl_wr_seq.sv
module pwl_wr_seq
  import pwl_lut_pkg::*;
#(
  parameter int NPTS  = 64,
  parameter int DW    = 16,
  parameter int IDX_W = $clog2(NPTS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             idx_clr_i,
  input  logic                             data_vld_i,
  input  logic [DW-1:0]                    data_i,
  input  logic [CH_N-1:0]                  wr_mask_i,
  input  logic                             wr_sel_i,
  output logic [BANK_N-1:0][CH_N-1:0]      we_o,
  output logic                             dlt_o,
  output logic [IDX_W-1:0]                 addr_o,
  output logic [DW-1:0]                    wdata_o
);
  localparam int PT_W = $clog2(NPTS + 1);
  localparam logic [PT_W-1:0] PT_END = PT_W'(NPTS);

  logic [2:0]      wcnt_q;
  logic [PT_W-1:0] pt_q;
  logic            full;
  logic            accept;
  logic [1:0]      ch_idx;

  assign full   = (pt_q == PT_END);
  assign accept = data_vld_i && !idx_clr_i && !full;

  // word 0..2 bases, 3..5 deltas, channel order R,G,B in each half
  always_comb begin
    ch_idx = (wcnt_q >= 3'd3) ? 2'(wcnt_q - 3'd3) : wcnt_q[1:0];
    for (int b = 0; b < BANK_N; b++) begin
      for (int c = 0; c < CH_N; c++) begin
        we_o[b][c] = accept && wr_mask_i[c] && (ch_idx == 2'(c)) && (wr_sel_i == 1'(b));
      end
    end
  end

  assign dlt_o   = (wcnt_q >= 3'd3);
  assign addr_o  = pt_q[IDX_W-1:0];
  assign wdata_o = data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      pt_q   <= '0;
    end else if (idx_clr_i) begin
      wcnt_q <= '0;
      pt_q   <= '0;
    end else if (accept) begin
      if (wcnt_q == 3'(WORDS_PT - 1)) begin
        wcnt_q <= '0;
        pt_q   <= pt_q + 1'b1;
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  // R5
  clr_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_clr_i |=> (pt_q == '0) && (wcnt_q == '0));

  // R2
  point_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && wcnt_q == 3'd5) |=> (wcnt_q == '0) && (pt_q == $past(pt_q) + 1'b1));

  // R6
  full_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !idx_clr_i) |=> $stable(pt_q) && $stable(wcnt_q) && (we_o == '0));

  // R2
  wcnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q < 3'(WORDS_PT));
endmodule

// File: rtl/pwl_bank.sv
module pwl_bank
  import pwl_lut_pkg::*;
#(
  parameter int NPTS  = 64,
  parameter int DW    = 16,
  parameter int IDX_W = $clog2(NPTS)
) (
  input  logic                       clk_i,
  input  logic [CH_N-1:0]            we_i,
  input  logic                       dlt_i,
  input  logic [IDX_W-1:0]           waddr_i,
  input  logic [DW-1:0]              wdata_i,
  input  logic [CH_N-1:0][IDX_W-1:0] raddr_i,
  output logic [CH_N-1:0][DW-1:0]    base_o,
  output logic [CH_N-1:0][DW-1:0]    dlt_o
);
  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic [DW-1:0] base_mem [NPTS];
    logic [DW-1:0] dlt_mem  [NPTS];

    always_ff @(posedge clk_i) begin
      if (we_i[c]) begin
        if (dlt_i) dlt_mem[waddr_i]  <= wdata_i;
        else       base_mem[waddr_i] <= wdata_i;
      end
    end

    assign base_o[c] = base_mem[raddr_i[c]];
    assign dlt_o[c]  = dlt_mem[raddr_i[c]];
  end
endmodule

// File: rtl/pwl_mode_ctl.sv
module pwl_mode_ctl
  import pwl_lut_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_wr_i,
  input  logic [2:0] mode_i,
  input  logic       frame_start_i,
  output lut_mode_e  act_mode_o,
  output logic [3:0] status_o
);
  lut_mode_e pend_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= MODE_BYP;
      act_q  <= MODE_BYP;
    end else begin
      if (frame_start_i) act_q <= pend_q;
      if (mode_wr_i && mode_code_ok(mode_i)) pend_q <= lut_mode_e'(mode_i);
    end
  end

  always_comb begin
    case (act_q)
      MODE_RAM_A: status_o = STAT_A;
      MODE_RAM_B: status_o = STAT_B;
      default:    status_o = STAT_BYP;
    endcase
  end

  assign act_mode_o = act_q;

  // R7
  frame_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(act_q));

  // R7
  bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wr_i && !mode_code_ok(mode_i)) |=> $stable(pend_q));

  // R8
  status_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(status_o) |-> $past(frame_start_i));
endmodule

// File: rtl/pwl_interp.sv
module pwl_interp #(
  parameter int DW    = 16,
  parameter int FW    = 8,
  parameter int PIX_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             byp_i,
  input  logic [DW-1:0]    base_i,
  input  logic [DW-1:0]    dlt_i,
  input  logic [FW-1:0]    frac_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [DW-1:0]    out_o
);
  localparam int PROD_W = DW + FW;

  logic [PROD_W-1:0] prod;
  logic [DW-1:0]     step;
  logic [DW-1:0]     lut_val;

  assign prod    = PROD_W'(dlt_i) * PROD_W'(frac_i);
  assign step    = prod[PROD_W-1:FW];
  assign lut_val = base_i + step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   out_o <= '0;
    else if (en_i) out_o <= byp_i ? DW'(pix_i) : lut_val;
  end

  // R9
  zero_frac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !byp_i && frac_i == '0) |=> out_o == $past(base_i));

  // R9
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(out_o));
endmodule

// File: rtl/pwl_pingpong_lut.sv
module pwl_pingpong_lut
  import pwl_lut_pkg::*;
#(
  parameter int NPTS  = 64,
  parameter int DW    = 16,
  parameter int FW    = 8,
  parameter int IDX_W = $clog2(NPTS),
  parameter int PIX_W = IDX_W + FW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_sel_i,
  input  logic [2:0]       wr_mask_i,
  input  logic             idx_clr_i,
  input  logic             data_vld_i,
  input  logic [DW-1:0]    data_i,
  input  logic             mode_wr_i,
  input  logic [2:0]       mode_i,
  input  logic             frame_start_i,
  output logic [3:0]       status_o,
  input  logic             pix_vld_i,
  input  logic [PIX_W-1:0] pix_r_i,
  input  logic [PIX_W-1:0] pix_g_i,
  input  logic [PIX_W-1:0] pix_b_i,
  output logic             pix_vld_o,
  output logic [DW-1:0]    out_r_o,
  output logic [DW-1:0]    out_g_o,
  output logic [DW-1:0]    out_b_o
);
  logic [BANK_N-1:0][CH_N-1:0] we;
  logic                        w_dlt;
  logic [IDX_W-1:0]            w_addr;
  logic [DW-1:0]               w_data;
  lut_mode_e                   act_mode;

  logic [CH_N-1:0][PIX_W-1:0]  pix_in;
  logic [CH_N-1:0][IDX_W-1:0]  raddr;
  logic [BANK_N-1:0][CH_N-1:0][DW-1:0] rd_base, rd_dlt;
  logic [CH_N-1:0][DW-1:0]     out_w;

  logic                        s1_vld, s1_byp;
  logic [CH_N-1:0][DW-1:0]     s1_base, s1_dlt;
  logic [CH_N-1:0][PIX_W-1:0]  s1_pix;
  logic                        s2_vld;

  assign pix_in = {pix_b_i, pix_g_i, pix_r_i};

  pwl_wr_seq #(.NPTS(NPTS), .DW(DW), .IDX_W(IDX_W)) u_wr_seq (
    .clk_i, .rst_ni,
    .idx_clr_i, .data_vld_i, .data_i, .wr_mask_i, .wr_sel_i,
    .we_o(we), .dlt_o(w_dlt), .addr_o(w_addr), .wdata_o(w_data)
  );

  pwl_mode_ctl u_mode_ctl (
    .clk_i, .rst_ni, .mode_wr_i, .mode_i, .frame_start_i,
    .act_mode_o(act_mode), .status_o
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_addr
    assign raddr[c] = pix_in[c][PIX_W-1:FW];
  end

  for (genvar b = 0; b < BANK_N; b++) begin : g_bank
    pwl_bank #(.NPTS(NPTS), .DW(DW), .IDX_W(IDX_W)) u_bank (
      .clk_i,
      .we_i(we[b]), .dlt_i(w_dlt), .waddr_i(w_addr), .wdata_i(w_data),
      .raddr_i(raddr), .base_o(rd_base[b]), .dlt_o(rd_dlt[b])
    );
  end

  // stage 1: table read, bank picked by the mode live at entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_byp  <= 1'b1;
      s1_base <= '0;
      s1_dlt  <= '0;
      s1_pix  <= '0;
    end else begin
      s1_vld <= pix_vld_i;
      if (pix_vld_i) begin
        s1_byp  <= (act_mode == MODE_BYP);
        s1_base <= (act_mode == MODE_RAM_B) ? rd_base[1] : rd_base[0];
        s1_dlt  <= (act_mode == MODE_RAM_B) ? rd_dlt[1]  : rd_dlt[0];
        s1_pix  <= pix_in;
      end
    end
  end

  // stage 2: interpolation per channel
  for (genvar c = 0; c < CH_N; c++) begin : g_interp
    pwl_interp #(.DW(DW), .FW(FW), .PIX_W(PIX_W)) u_interp (
      .clk_i, .rst_ni,
      .en_i(s1_vld), .byp_i(s1_byp),
      .base_i(s1_base[c]), .dlt_i(s1_dlt[c]),
      .frac_i(s1_pix[c][FW-1:0]), .pix_i(s1_pix[c]),
      .out_o(out_w[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s2_vld <= 1'b0;
    else         s2_vld <= s1_vld;
  end

  assign pix_vld_o = s2_vld;
  assign out_r_o   = out_w[0];
  assign out_g_o   = out_w[1];
  assign out_b_o   = out_w[2];

  // R9
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_i |-> ##2 pix_vld_o);

  // R10
  bypass_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_vld_i && status_o == STAT_BYP) |-> ##2
      (out_r_o == DW'($past(pix_r_i, 2)) && out_b_o == DW'($past(pix_b_i, 2))));

  // R11
  bank_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_vld_i && act_mode == MODE_RAM_B) |=> (s1_base == $past(rd_base[1])));
endmodule

// File: tb/pwl_pingpong_lut_bench.sv
module pwl_pingpong_lut_bench;
  localparam int NPTS  = 64;
  localparam int DW    = 16;
  localparam int FW    = 8;
  localparam int IDX_W = 6;
  localparam int PIX_W = IDX_W + FW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             wr_sel = 0;
  logic [2:0]       wr_mask = 3'd7;
  logic             idx_clr = 0;
  logic             data_vld = 0;
  logic [DW-1:0]    data = '0;
  logic             mode_wr = 0;
  logic [2:0]       mode = '0;
  logic             frame_start = 0;
  logic [3:0]       status;
  logic             pix_vld = 0;
  logic [PIX_W-1:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic             pix_vld_o;
  logic [DW-1:0]    out_r, out_g, out_b;

  pwl_pingpong_lut u_pwl_pingpong_lut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_sel_i(wr_sel), .wr_mask_i(wr_mask), .idx_clr_i(idx_clr),
    .data_vld_i(data_vld), .data_i(data),
    .mode_wr_i(mode_wr), .mode_i(mode), .frame_start_i(frame_start),
    .status_o(status),
    .pix_vld_i(pix_vld), .pix_r_i(pix_r), .pix_g_i(pix_g), .pix_b_i(pix_b),
    .pix_vld_o(pix_vld_o), .out_r_o(out_r), .out_g_o(out_g), .out_b_o(out_b)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [DW-1:0] m_base [2][3][NPTS];
  logic [DW-1:0] m_dlt  [2][3][NPTS];
  int m_pend = 0, m_act = 0, m_pt = 0, m_w = 0;
  bit m_s1vld = 0, m_s1byp = 1, m_ovld = 0;
  int m_s1base [3], m_s1dlt [3], m_s1pix [3], m_out [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_act = 0; m_pt = 0; m_w = 0;
      m_s1vld = 0; m_ovld = 0;
      for (int c = 0; c < 3; c++) m_out[c] = 0;
    end else begin
      int pins [3];
      pins[0] = int'(pix_r); pins[1] = int'(pix_g); pins[2] = int'(pix_b);
      if (m_s1vld) begin
        for (int c = 0; c < 3; c++)
          m_out[c] = m_s1byp ? m_s1pix[c]
                   : ((m_s1base[c] + ((m_s1dlt[c] * (m_s1pix[c] % 256)) / 256)) % 65536);
      end
      m_ovld = m_s1vld;
      m_s1vld = pix_vld;
      if (pix_vld) begin
        int bk;
        bk = (m_act == 4) ? 1 : 0;
        m_s1byp = (m_act == 0);
        for (int c = 0; c < 3; c++) begin
          m_s1pix[c]  = pins[c];
          m_s1base[c] = int'(m_base[bk][c][pins[c] / 256]);
          m_s1dlt[c]  = int'(m_dlt[bk][c][pins[c] / 256]);
        end
      end
      if (idx_clr) begin
        m_pt = 0; m_w = 0;
      end else if (data_vld && m_pt < NPTS) begin
        int ch;
        ch = m_w % 3;
        if (wr_mask[ch]) begin
          if (m_w < 3) m_base[wr_sel][ch][m_pt] = data;
          else         m_dlt[wr_sel][ch][m_pt]  = data;
        end
        m_w++;
        if (m_w == 6) begin m_w = 0; m_pt++; end
      end
      if (frame_start) m_act = m_pend;
      if (mode_wr && (mode == 0 || mode == 3 || mode == 4)) m_pend = int'(mode);
    end
  end

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_st;
      int outs [3];
      exp_st = (m_act == 3) ? 9 : (m_act == 4) ? 10 : 0;
      chk(status == 4'(exp_st), {cur_req, "/R8 status"}, int'(status), exp_st);
      chk(pix_vld_o == m_ovld, {cur_req, "/R9 valid"}, int'(pix_vld_o), int'(m_ovld));
      outs[0] = int'(out_r); outs[1] = int'(out_g); outs[2] = int'(out_b);
      if (m_ovld) begin
        for (int c = 0; c < 3; c++)
          chk(outs[c] == m_out[c], {cur_req, "/R9/R10 data"}, outs[c], m_out[c]);
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [DW-1:0] val(input int seed, input int p, input int w);
    return DW'(seed * 4099 + p * 311 + w * 71 + 5);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clr_idx(input bit with_data);
    idx_clr = 1; data_vld = with_data; data = 16'hDEAD;
    step();
    idx_clr = 0; data_vld = 0;
  endtask

  task automatic stream_pts(input int seed, input int n);
    for (int p = 0; p < n; p++) begin
      for (int w = 0; w < 6; w++) begin
        data_vld = 1; data = val(seed, p, w);
        step();
      end
    end
    data_vld = 0;
  endtask

  task automatic load(input bit sel, input logic [2:0] msk, input int seed, input int n);
    wr_sel = sel; wr_mask = msk;
    clr_idx(0);
    stream_pts(seed, n);
  endtask

  task automatic set_mode(input logic [2:0] code, input bit with_frame);
    mode_wr = 1; mode = code; frame_start = with_frame;
    step();
    mode_wr = 0; frame_start = 0;
  endtask

  task automatic frame();
    frame_start = 1; step(); frame_start = 0;
  endtask

  task automatic pixels(input int n);
    // corners first: point 0 frac 0, last point full frac, mid
    for (int i = 0; i < n; i++) begin
      pix_vld = 1;
      if (i == 0)      begin pix_r = '0;           pix_g = 14'h3FFF;     pix_b = 14'h2000; end
      else if (i == 1) begin pix_r = 14'h3F00;     pix_g = 14'h00FF;     pix_b = 14'h1F80; end
      else begin
        pix_r = PIX_W'($urandom); pix_g = PIX_W'($urandom); pix_b = PIX_W'($urandom);
      end
      step();
    end
    pix_vld = 0;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state at the ports
    #1;
    chk(status == 4'd0, "R1 status", int'(status), 0);
    chk(pix_vld_o == 1'b0, "R1 valid", int'(pix_vld_o), 0);
    chk({out_r, out_g, out_b} == '0, "R1 outputs", int'(out_r | out_g | out_b), 0);
    step();

    cur_req = "R10"; pixels(20); repeat (3) step();

    cur_req = "R6";  load(0, 3'd7, 1, NPTS + 2);   // R2 order, extra points dropped
    cur_req = "R2";  load(1, 3'd7, 2, NPTS);

    cur_req = "R7";  set_mode(3'd3, 0); pixels(10); repeat (3) step();
    chk(status == 4'd0, "R7 no switch before frame", int'(status), 0);
    frame();
    chk(status == 4'd9, "R8 table A live", int'(status), 9);
    pixels(40); repeat (3) step();

    cur_req = "R4";
    fork
      load(1, 3'd7, 4, NPTS);
      pixels(300);
    join
    repeat (3) step();

    cur_req = "R3";
    fork
      load(1, 3'd5, 6, NPTS);
      pixels(300);
    join
    repeat (3) step();

    cur_req = "R7"; set_mode(3'd5, 0); frame(); pixels(10); repeat (3) step();
    chk(status == 4'd9, "R7 bad code ignored", int'(status), 9);

    cur_req = "R7"; set_mode(3'd4, 1); pixels(10); repeat (3) step();
    chk(status == 4'd9, "R7 same-cycle write waits", int'(status), 9);
    frame();
    cur_req = "R11"; pixels(60); repeat (3) step();
    chk(status == 4'd10, "R8 table B live", int'(status), 10);

    cur_req = "R5";
    wr_sel = 0; wr_mask = 3'd7; clr_idx(0);
    stream_pts(7, 3);
    clr_idx(1);
    stream_pts(8, 2);
    data_vld = 1; data = 16'h1234; step(); data_vld = 0;
    set_mode(3'd3, 0); frame(); pixels(300); repeat (3) step();

    cur_req = "R10"; set_mode(3'd0, 0); frame(); pixels(40); repeat (4) step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule